// File: doc/BRIEF.md
# PCI Configuration Request Encoder

This block turns a configuration-space access into the words a PCI host bridge needs to run the cycle. Software loads a target word (bus, device, function, register offset) and a write-data word through a small register bus, then writes a command word giving size, direction and whether the access goes to a remote device or to the bridge's own registers. The block forms the address word and the command/byte-enable word, aligns the write data onto its byte lanes and issues a one-cycle request strobe.

When the bridge reports completion, the block pulls the addressed bytes out of the returned dword and masks them to the access width. If the bridge reports a bus error, it returns all ones of the access width and raises a device-not-found flag. Size and offset combinations that cannot be expressed as contiguous lanes within one dword are refused and never reach the bridge.

Top module: `cfg_req_encoder`

## Requirements
- R1: For a remote access with bus number zero, `req_addr` is a one-hot bit at position equal to the device number, OR-ed with the function number at bits 10:8 and the offset with bits 1:0 cleared.
- R2: For a remote access with a non-zero bus number, `req_addr` holds bus at 23:16, device at 15:11, function at 10:8, the offset with bits 1:0 cleared, and bit 0 set.
- R3: The active-low lane enables are 0x0 for size 4 at offset 0; 0xE, 0xD, 0xB, 0x7 for size 1 at offset bits 0..3; 0xC for size 2 at offset 0 and 0x3 for size 2 at offset 2.
- R4: Any other size/offset pair, including every size code other than 1, 2 and 4, pulses `bad_req` for one cycle and issues no request; `busy` stays low.
- R5: For a remote access, `req_ctl` carries the lane enables at bits 7:4 and code 0xA (read) or 0xB (write) at bits 3:0, all other bits zero.
- R6: For a local access, `req_ctl` carries the lane enables at bits 23:20, bit 16 set for a write and clear for a read, and the offset with bits 1:0 cleared at bits 7:0; `req_addr` holds that same aligned offset.
- R7: `req_wdata` is the stored write data shifted left by 8 times offset bits 1:0.
- R8: On completion, `rsp_data` is the returned dword shifted right by 8 times offset bits 1:0 and masked to 0xFF, 0xFFFF or 0xFFFFFFFF for sizes 1, 2 and 4, with `rsp_notfound` low.
- R9: On a completion with `cpl_err` high, `rsp_data` is all ones of the access width and `rsp_notfound` is high.
- R10: A legal command write raises `req_valid` for exactly one cycle and sets `busy`; command writes while `busy` are ignored; `busy` clears and `rsp_valid` pulses one cycle after `cpl_valid`.
- R11: After reset `req_valid`, `busy`, `bad_req` and `rsp_valid` are low.

Register bus: `reg_sel` 0 writes the target word (bus 23:16, device 15:11, function 10:8, offset 7:0); 1 writes the write data; 2 writes the command (bit 0 write, bit 1 local, bits 4:2 size code) and starts the request. Every output changes on the clock edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| req_valid | output | 1 | One-cycle request strobe |
| req_addr | output | 32 | Encoded address word |
| req_ctl | output | 32 | Command and lane-enable word |
| req_wdata | output | 32 | Lane-aligned write data |
| busy | output | 1 | Request outstanding |
| bad_req | output | 1 | One-cycle pulse for a refused request |
| cpl_valid | input | 1 | Bridge completion strobe |
| cpl_data | input | 32 | Dword returned by the bridge |
| cpl_err | input | 1 | Bus error reported for the access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Extracted, width-masked read data |
| rsp_notfound | output | 1 | Device-not-found indication |

## Verification
The bench walks every size code against every offset, so a lane table with a swapped entry, or one that accepts a size-2 access at offset 1 or 3, shows up as wrong enables or a request that should have been refused. Type 0 and type 1 addresses are compared with low device numbers whose one-hot bit overlaps the offset bits, catching a design that forgets bit 0 on type 1 or misplaces the function field. Local accesses check that the enables move to bits 23:20 and that bit 16 tracks direction; a design using the remote position would emit 0xA/0xB codes instead. Read extraction, error completions at each width, and a command written while busy (which a faulty design would reissue, overwriting the saved lane shift) close the set.

// File: rtl/cfg_req_encoder.sv
module cfg_req_encoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic        req_valid,
  output logic [31:0] req_addr,
  output logic [31:0] req_ctl,
  output logic [31:0] req_wdata,
  output logic        busy,
  output logic        bad_req,
  input  logic        cpl_valid,
  input  logic [31:0] cpl_data,
  input  logic        cpl_err,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        rsp_notfound
);
  localparam logic [1:0] SEL_TGT  = 2'd0;
  localparam logic [1:0] SEL_WDAT = 2'd1;
  localparam logic [1:0] SEL_CMD  = 2'd2;
  localparam logic [3:0] CODE_RD  = 4'hA;
  localparam logic [3:0] CODE_WR  = 4'hB;
  localparam logic [3:0] LANES_NONE = 4'hF;

  logic [23:0] tgt_q;
  logic [31:0] wdat_q;
  logic [1:0]  sh_q;
  logic [31:0] mask_q;
  logic        lcl_q;

  wire [7:0] t_bus = tgt_q[23:16];
  wire [4:0] t_dev = tgt_q[15:11];
  wire [2:0] t_fn  = tgt_q[10:8];
  wire [7:0] t_ofs = tgt_q[7:0];
  wire [7:0] ofs_dw = {t_ofs[7:2], 2'b00};

  wire       c_wr   = reg_wdata[0];
  wire       c_lcl  = reg_wdata[1];
  wire [2:0] c_size = reg_wdata[4:2];

  logic [3:0]  lanes;
  logic [31:0] size_mask;

  always_comb begin
    lanes = LANES_NONE;
    case (c_size)
      3'd1: lanes = ~(4'b0001 << t_ofs[1:0]);
      3'd2: if (!t_ofs[0]) lanes = t_ofs[1] ? 4'h3 : 4'hC;
      3'd4: if (t_ofs[1:0] == 2'd0) lanes = 4'h0;
      default: lanes = LANES_NONE;
    endcase
  end

  always_comb begin
    case (c_size)
      3'd1:    size_mask = 32'h0000_00FF;
      3'd2:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  end

  wire [31:0] addr_t0 = (32'd1 << t_dev) | {21'd0, t_fn, ofs_dw};
  wire [31:0] addr_t1 = {8'd0, t_bus, t_dev, t_fn, t_ofs[7:2], 2'b01};
  wire [31:0] ctl_lcl = {8'd0, lanes, 3'd0, c_wr, 8'd0, ofs_dw};
  wire [31:0] ctl_rem = {24'd0, lanes, c_wr ? CODE_WR : CODE_RD};

  wire issue_try = reg_we && (reg_sel == SEL_CMD) && !busy;
  wire legal     = (lanes != LANES_NONE);
  wire [31:0] rsp_src = cpl_err ? 32'hFFFF_FFFF : cpl_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q        <= '0;
      wdat_q       <= '0;
      sh_q         <= '0;
      mask_q       <= '0;
      lcl_q        <= 1'b0;
      req_valid    <= 1'b0;
      req_addr     <= '0;
      req_ctl      <= '0;
      req_wdata    <= '0;
      busy         <= 1'b0;
      bad_req      <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_notfound <= 1'b0;
    end else begin
      req_valid <= 1'b0;
      bad_req   <= 1'b0;
      rsp_valid <= 1'b0;
      if (reg_we && reg_sel == SEL_TGT)  tgt_q  <= reg_wdata[23:0];
      if (reg_we && reg_sel == SEL_WDAT) wdat_q <= reg_wdata;
      if (issue_try) begin
        if (legal) begin
          req_valid <= 1'b1;
          busy      <= 1'b1;
          req_addr  <= c_lcl ? {24'd0, ofs_dw} : ((t_bus == 8'd0) ? addr_t0 : addr_t1);
          req_ctl   <= c_lcl ? ctl_lcl : ctl_rem;
          req_wdata <= wdat_q << {t_ofs[1:0], 3'b000};
          sh_q      <= t_ofs[1:0];
          mask_q    <= size_mask;
          lcl_q     <= c_lcl;
        end else begin
          bad_req   <= 1'b1;
        end
      end
      if (busy && cpl_valid) begin
        busy         <= 1'b0;
        rsp_valid    <= 1'b1;
        rsp_data     <= (rsp_src >> {sh_q, 3'b000}) & mask_q;
        rsp_notfound <= cpl_err;
      end
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid); // R10
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy); // R10
  AST_LANES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((lcl_q ? req_ctl[23:20] : req_ctl[7:4]) != 4'hF)); // R3
  AST_BAD_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req |-> (!req_valid && !busy)); // R4
  AST_RSP_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!busy && $past(busy))); // R10
  AST_ERR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_notfound) |-> (rsp_data == mask_q)); // R9
endmodule

// File: tb/tb_cfg_req_encoder.sv
module tb_cfg_req_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        req_valid, busy, bad_req, rsp_valid, rsp_notfound;
  logic [31:0] req_addr, req_ctl, req_wdata, rsp_data;
  logic        cpl_valid = 1'b0;
  logic [31:0] cpl_data = '0;
  logic        cpl_err = 1'b0;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  cfg_req_encoder dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_ctl(req_ctl), .req_wdata(req_wdata),
    .busy(busy), .bad_req(bad_req), .cpl_valid(cpl_valid), .cpl_data(cpl_data),
    .cpl_err(cpl_err), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_notfound(rsp_notfound)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic complete(input logic [31:0] d, input logic e);
    @(negedge clk); cpl_valid = 1'b1; cpl_data = d; cpl_err = e;
    @(negedge clk); cpl_valid = 1'b0;
  endtask

  task automatic run_cfg(input string tag, input logic [7:0] bnum, input logic [4:0] dev,
                         input logic [2:0] fn, input logic [7:0] ofs, input logic [2:0] size,
                         input logic wr, input logic loc, input logic [31:0] wd,
                         input logic [31:0] cd, input logic cerr);
    logic ok;
    logic [3:0] be;
    logic [31:0] ea, ec, mask, src;
    logic [7:0] al;
    al = ofs & 8'hFC;
    ok = (size == 3'd4 && ofs[1:0] == 2'd0) || (size == 3'd1) ||
         (size == 3'd2 && ofs[0] == 1'b0);
    be = 4'hF;
    if (ok) be = ~(4'(((1 << size) - 1) << ofs[1:0]));
    if (loc) ea = {24'd0, al};
    else if (bnum == 8'd0) ea = (32'd1 << dev) | (32'(fn) << 8) | 32'(al);
    else ea = (32'(bnum) << 16) | (32'(dev) << 11) | (32'(fn) << 8) | 32'(al) | 32'd1;
    if (loc) ec = (32'(be) << 20) | (32'(wr) << 16) | 32'(al);
    else ec = (32'(be) << 4) | (wr ? 32'hB : 32'hA);
    mask = (size == 3'd1) ? 32'hFF : (size == 3'd2) ? 32'hFFFF : 32'hFFFFFFFF;
    src = cerr ? 32'hFFFFFFFF : cd;
    wr_reg(2'd0, {8'd0, bnum, dev, fn, ofs});
    wr_reg(2'd1, wd);
    wr_reg(2'd2, {27'd0, size, loc, wr});
    if (!ok) begin
      chk({tag, " R4 bad_req"}, 32'(bad_req), 32'd1);
      chk({tag, " R4 no req"}, 32'(req_valid), 32'd0);
      chk({tag, " R4 busy"}, 32'(busy), 32'd0);
      return;
    end
    chk({tag, " R10 req_valid"}, 32'(req_valid), 32'd1);
    chk({tag, " addr"}, req_addr, ea);
    chk({tag, " ctl"}, req_ctl, ec);
    chk({tag, " R7 wdata"}, req_wdata, wd << (8 * ofs[1:0]));
    @(negedge clk);
    chk({tag, " R10 pulse"}, 32'(req_valid), 32'd0);
    chk({tag, " R10 busy"}, 32'(busy), 32'd1);
    complete(cd, cerr);
    chk({tag, " R10 rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " R10 busy clr"}, 32'(busy), 32'd0);
    chk({tag, " R8/R9 rsp_data"}, rsp_data, (src >> (8 * ofs[1:0])) & mask);
    chk({tag, " R9 notfound"}, 32'(rsp_notfound), 32'(cerr));
  endtask

  task automatic t_reset;
    chk("R11 req_valid", 32'(req_valid), 32'd0);
    chk("R11 busy", 32'(busy), 32'd0);
    chk("R11 bad_req", 32'(bad_req), 32'd0);
    chk("R11 rsp_valid", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_type0;
    run_cfg("R1 t0 dev0", 8'd0, 5'd0, 3'd0, 8'h00, 3'd4, 1'b0, 1'b0, 32'h0, 32'h12345678, 1'b0);
    run_cfg("R1 t0 dev3", 8'd0, 5'd3, 3'd5, 8'h3C, 3'd4, 1'b1, 1'b0, 32'hCAFEF00D, 32'h0, 1'b0);
    run_cfg("R1 t0 dev31", 8'd0, 5'd31, 3'd7, 8'hFD, 3'd1, 1'b0, 1'b0, 32'h0, 32'hA1B2C3D4, 1'b0);
  endtask

  task automatic t_type1;
    run_cfg("R2 t1 a", 8'd1, 5'd0, 3'd0, 8'h00, 3'd4, 1'b0, 1'b0, 32'h0, 32'h89ABCDEF, 1'b0);
    run_cfg("R2 t1 b", 8'hFF, 5'd31, 3'd7, 8'hFE, 3'd2, 1'b1, 1'b0, 32'h0000BEEF, 32'h0, 1'b0);
    run_cfg("R2 t1 c", 8'h5A, 5'd10, 3'd2, 8'h41, 3'd1, 1'b0, 1'b0, 32'h0, 32'h00FF1100, 1'b0);
  endtask

  task automatic t_lanes;
    for (int sz = 0; sz < 8; sz++)
      for (int o = 0; o < 4; o++)
        run_cfg($sformatf("R3 R5 lanes sz%0d o%0d", sz, o), 8'd0, 5'd2, 3'd1, 8'(8'h10 + o),
                3'(sz), 1'(o & 1), 1'b0, 32'h11223344, 32'h55667788, 1'b0);
  endtask

  task automatic t_local;
    run_cfg("R6 local wr", 8'h07, 5'd4, 3'd3, 8'h04, 3'd4, 1'b1, 1'b1, 32'h0000_0356, 32'h0, 1'b0);
    run_cfg("R6 local rd", 8'h00, 5'd9, 3'd0, 8'h4E, 3'd2, 1'b0, 1'b1, 32'h0, 32'hDEADBEEF, 1'b0);
    run_cfg("R6 local bad", 8'h00, 5'd9, 3'd0, 8'h4D, 3'd2, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0);
  endtask

  task automatic t_error;
    run_cfg("R9 err b", 8'd0, 5'd1, 3'd0, 8'h03, 3'd1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1);
    run_cfg("R9 err h", 8'd2, 5'd1, 3'd0, 8'h02, 3'd2, 1'b0, 1'b0, 32'h0, 32'h12340000, 1'b1);
    run_cfg("R9 err w", 8'd0, 5'd1, 3'd0, 8'h08, 3'd4, 1'b1, 1'b0, 32'h5, 32'h0, 1'b1);
  endtask

  task automatic t_busy;
    wr_reg(2'd0, {8'd0, 8'd0, 5'd6, 3'd0, 8'h13});
    wr_reg(2'd2, {27'd0, 3'd1, 1'b0, 1'b0});
    chk("R10 first req", 32'(req_valid), 32'd1);
    wr_reg(2'd0, {8'd0, 8'd0, 5'd6, 3'd0, 8'h20});
    wr_reg(2'd2, {27'd0, 3'd4, 1'b0, 1'b1});
    chk("R10 ignored while busy", 32'(req_valid), 32'd0);
    chk("R10 ignored no bad", 32'(bad_req), 32'd0);
    chk("R10 addr kept", req_addr, (32'd1 << 6) | 32'h10);
    complete(32'hA0B1C2D3, 1'b0);
    chk("R10 rsp first access", rsp_data, 32'h000000A0);
    chk("R10 idle", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_type0();
    t_type1();
    t_lanes();
    t_local();
    t_error();
    t_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule